// File: doc/BRIEF.md
# Routed System Interrupt Controller

This block collects thirty-two level-sensitive device interrupt lines and forwards them to processors as interrupt-level vectors. Each line passes a two-stage synchronizer and is then latched into a pending register, which tracks the line for as long as it is held. A disable register masks individual sources. Each surviving source maps through a fixed table onto one of fifteen processor levels. The resulting vector goes to a single selected target CPU, chosen from up to sixteen.

Three exceptions shape the routing. Several sources share a level. The top bit of the disable register stops all routing at once. Any source on level 15 is sent to every CPU, whatever its own disable bit says. Software reaches five word registers through a plain strobe port: pending, disable (read), clear-disable, set-disable and target. Reads are combinational and writes take effect at the next rising edge. The port has no back-pressure, because every access completes in the cycle it is presented.

Top module: `irq_router`

## Requirements
- R1: After reset the pending register reads 0, the disable register reads 0 through offset 0x4, the target reads 0, and every CPU vector is 0. Internally, disable resets to 0x0FA2007F.
- R2: A source whose level is nonzero sets its pending bit while its line is high and clears it when the line drops. Sources 23 to 26 and 31 map to level 0 and never set pending. Offset 0x0 reads pending with bit 31 at zero.
- R3: Source bits 0 to 31 map to levels 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. A source that is pending and not disabled sets bit L of the target CPU's 16-bit vector, where L is its level.
- R4: A write to 0x8 clears, and a write to 0xC sets, the disable bits selected by data AND 0xF05DFF80. Other disable bits never change. Neither write alters pending. Offset 0x4 reads disable AND 0xF05DFF80.
- R5: While disable bit 31 is set, every bit of every CPU vector is 0.
- R6: A write to 0x10 stores the low 4 bits of the data as the target, and offset 0x10 reads that value back. CPUs other than the target never have bits 14 to 0 set.
- R7: While any level-15 source (bits 27 to 30) is pending and bit 31 is clear, bit 15 is set in every CPU vector. This holds even if that source's own disable bit is set.
- R8: Offsets 0x8, 0xC and 0x14 to 0x1C read 0. Writes to 0x0, 0x4 and 0x14 to 0x1C change nothing.
- R9: An input that rises just after a clock edge shows in pending after the third following rising edge, and in the CPU vector after the fourth. Bit 0 of every vector is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 32 | Device interrupt lines, level-sensitive, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read, else 0 |
| cpu_lvl | output | 256 | Level vectors, CPU n at bits [16n+15:16n] |

## Verification
The hardest situation to reach is a level-15 source that is individually disabled yet still lights bit 15 on all sixteen CPUs. Source 27 is the only case that lies outside the writable mask. The bench reaches it by raising line 27 under the reset-time disable value. It repeats the test with line 30 after a set-disable write, and with master disable set. It also times one edge-by-edge pass through the synchronizer, pending and output registers, which shows that the latency is exactly four edges.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int SRC_N = 32;
  localparam int LVL_N = 16;
  localparam int LVL_W = 4;
  localparam int MASTER_BIT = 31;

  localparam logic [SRC_N-1:0] DIS_WR_MASK = 32'hF05DFF80;
  localparam logic [SRC_N-1:0] DIS_RESET   = 32'h0FA2007F;

  typedef enum logic [2:0] {
    RG_PEND   = 3'd0,
    RG_DIS    = 3'd1,
    RG_UNMASK = 3'd2,
    RG_MASK   = 3'd3,
    RG_TGT    = 3'd4
  } reg_idx_e;

  function automatic logic [LVL_W-1:0] src_level(input logic [4:0] s);
    case (s)
      5'd0,  5'd7:                 src_level = 4'd2;
      5'd1,  5'd8:                 src_level = 4'd3;
      5'd2,  5'd9:                 src_level = 4'd5;
      5'd3,  5'd10:                src_level = 4'd7;
      5'd4,  5'd11, 5'd21:         src_level = 4'd9;
      5'd5,  5'd12, 5'd22:         src_level = 4'd11;
      5'd6,  5'd13, 5'd17:         src_level = 4'd13;
      5'd14, 5'd15:                src_level = 4'd12;
      5'd16:                       src_level = 4'd6;
      5'd18:                       src_level = 4'd4;
      5'd19:                       src_level = 4'd10;
      5'd20:                       src_level = 4'd8;
      5'd27, 5'd28, 5'd29, 5'd30:  src_level = 4'd15;
      default:                     src_level = 4'd0;
    endcase
  endfunction

  function automatic logic [SRC_N-1:0] live_mask_f();
    logic [SRC_N-1:0] m;
    for (int s = 0; s < SRC_N; s++) m[s] = (src_level(5'(s)) != 4'd0);
    return m;
  endfunction

  function automatic logic [SRC_N-1:0] top_mask_f();
    logic [SRC_N-1:0] m;
    for (int s = 0; s < SRC_N; s++) m[s] = (src_level(5'(s)) == 4'd15);
    return m;
  endfunction

  localparam logic [SRC_N-1:0] LIVE_MASK = live_mask_f();
  localparam logic [SRC_N-1:0] TOP_MASK  = top_mask_f();

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 16,
  localparam int TGT_W = $clog2(NUM_CPU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] line_sync,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [4:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [SRC_N-1:0] pend_q,
  output logic [SRC_N-1:0] dis_q,
  output logic [TGT_W-1:0] tgt_q
);
  reg_idx_e idx;
  logic     wr, rd;
  logic [SRC_N-1:0] wmask;

  assign idx   = reg_idx_e'(bus_addr[4:2]);
  assign wr    = bus_sel && bus_we;
  assign rd    = bus_sel && !bus_we;
  assign wmask = bus_wdata & DIS_WR_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      dis_q  <= DIS_RESET;
      tgt_q  <= '0;
    end else begin
      pend_q <= line_sync & LIVE_MASK;
      if (wr) begin
        case (idx)
          RG_UNMASK: dis_q <= dis_q & ~wmask;
          RG_MASK:   dis_q <= dis_q | wmask;
          RG_TGT:    tgt_q <= bus_wdata[TGT_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (idx)
        RG_PEND: bus_rdata = pend_q & ~(32'd1 << MASTER_BIT);
        RG_DIS:  bus_rdata = dis_q & DIS_WR_MASK;
        RG_TGT:  bus_rdata = 32'(tgt_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R4
  unmask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == RG_UNMASK) |=> ((dis_q & $past(wmask)) == '0));
  // R4
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == RG_MASK) |=> ((dis_q & $past(wmask)) == $past(wmask)));
  // R4
  locked_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dis_q & ~DIS_WR_MASK) == $past(dis_q & ~DIS_WR_MASK)));
  // R6
  tgt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == RG_TGT) |=> (tgt_q == $past(bus_wdata[TGT_W-1:0])));
  // R8
  dead_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (idx == RG_PEND || idx == RG_DIS || bus_addr[4:2] > 3'd4))
      |=> ($stable(dis_q) && $stable(tgt_q)));
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_route_pkg::*;
(
  input  logic [SRC_N-1:0] pend,
  input  logic [SRC_N-1:0] dis,
  output logic [LVL_N-1:0] hard_lvl,
  output logic             top_any
);
  logic [SRC_N-1:0] armed;

  assign armed   = pend & ~dis;
  assign top_any = |(pend & TOP_MASK);

  always_comb begin
    hard_lvl = '0;
    for (int s = 0; s < SRC_N; s++) begin
      if (armed[s]) hard_lvl[src_level(5'(s))] = 1'b1;
    end
    hard_lvl[0] = 1'b0;
  end
endmodule

// File: rtl/irq_cpu_fanout.sv
module irq_cpu_fanout
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 16,
  localparam int TGT_W = $clog2(NUM_CPU)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LVL_N-1:0]         hard_lvl,
  input  logic                     top_any,
  input  logic                     master_off,
  input  logic [TGT_W-1:0]         tgt,
  output logic [NUM_CPU*LVL_N-1:0] cpu_lvl
);
  logic [LVL_N-1:0] lvl_q [NUM_CPU];

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    logic [LVL_N-1:0] nxt;

    always_comb begin
      nxt = '0;
      if (!master_off) begin
        if (tgt == TGT_W'(i)) nxt = hard_lvl;
        nxt[LVL_N-1] = nxt[LVL_N-1] | top_any;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[i] <= '0;
      else        lvl_q[i] <= nxt;
    end

    assign cpu_lvl[i*LVL_N +: LVL_N] = lvl_q[i];

    // R6
    off_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tgt) != TGT_W'(i)) |-> (lvl_q[i][LVL_N-2:0] == '0));
    // R5
    master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(master_off) |-> (lvl_q[i] == '0));
    // R7
    top_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(top_any) && !$past(master_off)) |-> lvl_q[i][LVL_N-1]);
    // R9
    no_lvl0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q[i][0] == 1'b0);
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 16,
  localparam int TGT_W = $clog2(NUM_CPU)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              dev_irq,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [4:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_CPU*16-1:0]    cpu_lvl
);
  logic [SRC_N-1:0] line_sync, pend_q, dis_q;
  logic [TGT_W-1:0] tgt_q;
  logic [LVL_N-1:0] hard_lvl;
  logic             top_any;

  irq_sync #(.W(SRC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dev_irq), .q(line_sync)
  );

  irq_ctl_regs #(.NUM_CPU(NUM_CPU)) u_regs (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_q(pend_q), .dis_q(dis_q), .tgt_q(tgt_q)
  );

  irq_level_map u_map (
    .pend(pend_q), .dis(dis_q), .hard_lvl(hard_lvl), .top_any(top_any)
  );

  irq_cpu_fanout #(.NUM_CPU(NUM_CPU)) u_fan (
    .clk(clk), .rst_n(rst_n), .hard_lvl(hard_lvl), .top_any(top_any),
    .master_off(dis_q[MASTER_BIT]), .tgt(tgt_q), .cpu_lvl(cpu_lvl)
  );
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
  localparam int NCPU = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] dev_irq = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCPU*16-1:0] cpu_lvl;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_router #(.NUM_CPU(NCPU)) dut (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_lvl(cpu_lvl)
  );

  // {irq, set-disable value, target, expected target vector, expected other vector}
  localparam int NV = 12;
  localparam logic [99:0] VECS [NV] = '{
    {32'h00000080, 32'h00000000, 4'd0,  16'h0004, 16'h0000},
    {32'h00000001, 32'h00000000, 4'd0,  16'h0000, 16'h0000},
    {32'h0000C000, 32'h00000000, 4'd3,  16'h1000, 16'h0000},
    {32'h005D0000, 32'h00000000, 4'd5,  16'h0D50, 16'h0000},
    {32'h10000000, 32'h00000000, 4'd2,  16'h8000, 16'h8000},
    {32'h08000000, 32'h00000000, 4'd1,  16'h8000, 16'h8000},
    {32'h00000300, 32'h00000100, 4'd0,  16'h0020, 16'h0000},
    {32'hFFFFFFFF, 32'h80000000, 4'd4,  16'h0000, 16'h0000},
    {32'h0F800000, 32'h00000000, 4'd7,  16'h8000, 16'h8000},
    {32'h40000000, 32'h40000000, 4'd15, 16'h8000, 16'h8000},
    {32'h00003C00, 32'h00000000, 4'd6,  16'h2A80, 16'h0000},
    {32'hFFFFFFFF, 32'h00000000, 4'd9,  16'hBFFC, 16'h8000}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [15:0] vec(input int c);
    return cpu_lvl[c*16 +: 16];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, d); check("R1", "pending", d, 32'h0);
    rd(5'h04, d); check("R1", "disable", d, 32'h0);
    rd(5'h10, d); check("R1", "target", d, 32'h0);
    bad = 0;
    for (int c = 0; c < NCPU; c++) if (vec(c) != 16'h0) bad++;
    check("R1", "nonzero vectors", bad, 0);

    // R9 latency: source 7 (level 2) is writable and enabled by reset
    @(negedge clk);
    dev_irq = 32'h00000080;
    @(negedge clk); @(negedge clk);
    rd(5'h00, d); check("R9", "pending after 2 edges", d, 32'h0);
    @(negedge clk);
    rd(5'h00, d); check("R9", "pending after 3 edges", d, 32'h80);
    check("R9", "vector after 3 edges", 32'(vec(0)), 32'h0);
    @(negedge clk);
    check("R9", "vector after 4 edges", 32'(vec(0)), 32'h0004);
    dev_irq = '0;
    repeat (6) @(negedge clk);

    // R7 source 27 is locked disabled but still broadcast
    dev_irq = 32'h08000000;
    repeat (6) @(negedge clk);
    bad = 0;
    for (int c = 0; c < NCPU; c++) if (vec(c) != 16'h8000) bad++;
    check("R7", "cpus missing level 15", bad, 0);
    dev_irq = '0;
    repeat (6) @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [31:0] irq, dset;
      logic [3:0]  tg;
      logic [15:0] et, eo;
      {irq, dset, tg, et, eo} = VECS[v];
      wr(5'h08, 32'hFFFFFFFF);
      wr(5'h0C, dset);
      wr(5'h10, {28'h0, tg});
      dev_irq = irq;
      repeat (8) @(negedge clk);
      rd(5'h00, d); check("R2", "pending", d, irq & 32'h787FFFFF);
      rd(5'h04, d); check("R4", "disable readback", d, dset & 32'hF05DFF80);
      rd(5'h10, d); check("R6", "target readback", d, {28'h0, tg});
      check("R3", "target vector", 32'(vec(int'(tg))), 32'(et));
      bad = 0;
      for (int c = 0; c < NCPU; c++)
        if (c != int'(tg) && vec(c) != eo) bad++;
      check("R6", "non-target vectors differing", bad, 0);
      dev_irq = '0;
      repeat (6) @(negedge clk);
    end

    // R4 disable write leaves pending alone
    wr(5'h08, 32'hFFFFFFFF);
    wr(5'h10, 32'h0);
    dev_irq = 32'h00000200;
    repeat (6) @(negedge clk);
    check("R3", "source 9 level 5", 32'(vec(0)), 32'h0020);
    wr(5'h0C, 32'h00000200);
    @(negedge clk);
    rd(5'h00, d); check("R4", "pending kept under disable", d, 32'h200);
    check("R4", "disabled source routed", 32'(vec(0)), 32'h0);

    // R5 master disable also blocks broadcast
    dev_irq = 32'h20000000;
    wr(5'h0C, 32'h80000000);
    repeat (6) @(negedge clk);
    bad = 0;
    for (int c = 0; c < NCPU; c++) if (vec(c) != 16'h0) bad++;
    check("R5", "vectors under master disable", bad, 0);
    wr(5'h08, 32'h80000000);
    repeat (2) @(negedge clk);
    check("R7", "broadcast after master cleared", 32'(vec(11)), 32'h8000);
    dev_irq = '0;

    // R6 target takes low 4 bits only
    wr(5'h10, 32'h00000025);
    rd(5'h10, d); check("R6", "target truncated", d, 32'h5);

    // R8 unlisted offsets and read-only registers
    wr(5'h0C, 32'h00010000);
    wr(5'h00, 32'hFFFFFFFF);
    wr(5'h04, 32'hFFFFFFFF);
    wr(5'h14, 32'hFFFFFFFF);
    wr(5'h1C, 32'h00000003);
    rd(5'h04, d); check("R8", "disable unchanged", d, 32'h00010200);
    rd(5'h10, d); check("R8", "target unchanged", d, 32'h5);
    rd(5'h08, d); check("R8", "read 0x8", d, 32'h0);
    rd(5'h0C, d); check("R8", "read 0xC", d, 32'h0);
    rd(5'h14, d); check("R8", "read 0x14", d, 32'h0);
    rd(5'h1C, d); check("R8", "read 0x1C", d, 32'h0);

    // R2 level-0 sources only
    dev_irq = 32'h87800000;
    repeat (6) @(negedge clk);
    rd(5'h00, d); check("R2", "level-0 pending", d, 32'h0);
    check("R9", "bit 0 of target", 32'(vec(5)), 32'h0);
    dev_irq = '0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule